// File: doc/BRIEF.md
# Field memory write port controller

This block drives the write side of a serial field-delay memory. It runs on the serial write clock and turns a field reset, a pointer enable, a write mask and a 16-bit input word into the address, write strobe and data for one port of a simple dual-port RAM. An internal write pointer walks through the RAM from address zero, so the distance between this pointer and a read pointer elsewhere sets the delay of the memory.

Two enables act on the stream, and each takes effect two clocks after it is sampled. The pointer enable (`wrEn`) decides whether the pointer moves at all. The mask (`inEn`) only blocks the RAM write, so a masked word still uses up its address. After a field reset, the pointer enable has to stay low for a hold-off window. The first raise of the enable after that window starts a short start-up phase, and the word sampled after it lands at address zero. A raise inside the window, or a drop during the start-up phase, is ignored and sets a sticky error flag. The RAM depth and the hold-off length are parameters.

Top module: `field_wr_port`

## Requirements
- R1: A clock edge that samples `wrReset` high clears the pointer to zero, cancels every write still in the pipeline, clears `holdErr` and restarts the hold-off. The next word written goes to address 0.
- R2: When the controller is running and samples `wrEn`=1 and `inEn`=1, it writes the sampled word to the current pointer address and then increments the pointer. `ramWe`, `ramAddr` and `ramData` are registered and all change on the same edge.
- R3: When the controller is running and samples `wrEn`=1 and `inEn`=0, it makes no write strobe but still increments the pointer.
- R4: When the controller samples `wrEn`=0, it makes no write strobe and the pointer holds, whatever the level of `inEn`.
- R5: Inputs sampled at edge k appear at the RAM port after edge k+1, so the RAM takes the write at edge k+2. This gives a control latency of two clocks.
- R6: After the hold-off, the first edge that samples `wrEn`=1 and the edge after it form the start-up phase. The word sampled at the next edge is written to address 0, and its write strobe is on the port after the fourth edge counted from the first `wrEn` high.
- R7: During the HOLD_CYCLES edges that follow a reset, `wrEn`=1 is ignored and sets `holdErr`. `holdErr` stays set until the next reset.
- R8: If `wrEn` is low at the second edge of the start-up phase, `holdErr` is set. The start-up phase still ends at that edge.
- R9: After address DEPTH-1, the pointer wraps to address 0.
- R10: While `rstN` is low, `ramWe` and `holdErr` are 0. When `rstN` is released, the block behaves as if it had just taken a field reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial write clock |
| rstN | input | 1 | Asynchronous active-low system reset |
| wrReset | input | 1 | Field reset, sampled on the rising edge |
| wrEn | input | 1 | Pointer enable: high advances the pointer |
| inEn | input | 1 | Write mask: low blocks the RAM write |
| dataIn | input | DW (16) | Input word |
| ramWe | output | 1 | RAM write strobe |
| ramAddr | output | AW ($clog2(DEPTH)) | RAM write address |
| ramData | output | DW (16) | RAM write data |
| holdErr | output | 1 | Sticky error for an enable raise inside the hold-off or a drop during start-up |

## Verification
The block is driven with several input patterns:
- An unbroken run with the mask open. This checks the start-up timing at address 0 and, once it runs past DEPTH words, the wrap.
- A mask that toggles on alternate words. This separates a skipped address (R3) from a stalled pointer.
- Gaps in the pointer enable with the mask still high. These show that `inEn` alone cannot move the pointer or write.
- A field reset in the middle of a stream. This shows that the in-flight words are cancelled and that writing restarts at address 0.
- An enable raised inside the hold-off, and an enable dropped during start-up. These show that the early raise is ignored, that `holdErr` is set, and that the next reset clears it.

// File: rtl/field_wr_port_pkg.sv
package field_wr_port_pkg;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_ARMED = 2'd1,
    ST_START = 2'd2,
    ST_RUN   = 2'd3
  } wrState_e;

  typedef struct packed {
    logic clear;
    logic advance;
    logic write;
  } wrStrobe_t;

endpackage

// File: rtl/field_wr_port_ctrl.sv
module field_wr_port_ctrl
  import field_wr_port_pkg::*;
#(
  parameter int HOLD_CYCLES = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrReset,
  input  logic      wrEn,
  input  logic      inEn,
  output wrStrobe_t strb,
  output logic      holdErr
);

  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] HOLD_LOAD = CW'(HOLD_CYCLES);
  localparam logic [CW-1:0] HOLD_LAST = CW'(1);

  wrState_e      state;
  logic [CW-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_HOLD;
      holdCnt <= HOLD_LOAD;
      holdErr <= 1'b0;
    end else if (wrReset) begin
      state   <= ST_HOLD;
      holdCnt <= HOLD_LOAD;
      holdErr <= 1'b0;
    end else begin
      unique case (state)
        ST_HOLD: begin
          if (wrEn) holdErr <= 1'b1;
          if (holdCnt <= HOLD_LAST) state <= ST_ARMED;
          else holdCnt <= holdCnt - 1'b1;
        end
        ST_ARMED: begin
          if (wrEn) state <= ST_START;
        end
        ST_START: begin
          if (!wrEn) holdErr <= 1'b1;
          state <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    strb.clear   = wrReset;
    strb.advance = (state == ST_RUN) && wrEn && !wrReset;
    strb.write   = strb.advance && inEn;
  end

endmodule

// File: rtl/field_wr_port_path.sv
module field_wr_port_path
  import field_wr_port_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int DW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  wrStrobe_t     strb,
  input  logic [DW-1:0] dataIn,
  output logic          ramWe,
  output logic [AW-1:0] ramAddr,
  output logic [DW-1:0] ramData
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic          s1Adv;
  logic          s1Wr;
  logic [DW-1:0] s1Data;
  logic [AW-1:0] ptr;
  logic [AW-1:0] ptrNext;

  always_comb begin
    ptrNext = (ptr == LAST_ADDR) ? '0 : ptr + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Adv   <= 1'b0;
      s1Wr    <= 1'b0;
      s1Data  <= '0;
      ptr     <= '0;
      ramWe   <= 1'b0;
      ramAddr <= '0;
      ramData <= '0;
    end else if (strb.clear) begin
      s1Adv   <= 1'b0;
      s1Wr    <= 1'b0;
      s1Data  <= '0;
      ptr     <= '0;
      ramWe   <= 1'b0;
      ramAddr <= '0;
      ramData <= '0;
    end else begin
      s1Adv   <= strb.advance;
      s1Wr    <= strb.write;
      s1Data  <= dataIn;
      ramWe   <= s1Wr;
      ramAddr <= ptr;
      ramData <= s1Data;
      if (s1Adv) ptr <= ptrNext;
    end
  end

endmodule

// File: rtl/field_wr_port.sv
module field_wr_port
  import field_wr_port_pkg::*;
#(
  parameter int DEPTH       = 1024,
  parameter int DW          = 16,
  parameter int HOLD_CYCLES = 8,
  localparam int AW         = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrReset,
  input  logic          wrEn,
  input  logic          inEn,
  input  logic [DW-1:0] dataIn,
  output logic          ramWe,
  output logic [AW-1:0] ramAddr,
  output logic [DW-1:0] ramData,
  output logic          holdErr
);

  wrStrobe_t strb;

  field_wr_port_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrReset (wrReset),
    .wrEn    (wrEn),
    .inEn    (inEn),
    .strb    (strb),
    .holdErr (holdErr)
  );

  field_wr_port_path #(.DEPTH(DEPTH), .DW(DW)) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .dataIn  (dataIn),
    .ramWe   (ramWe),
    .ramAddr (ramAddr),
    .ramData (ramData)
  );

endmodule

// File: rtl/field_wr_port_chk.sv
module field_wr_port_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          wrReset,
  input logic          wrEn,
  input logic          inEn,
  input logic [DW-1:0] dataIn,
  input logic          ramWe,
  input logic [DW-1:0] ramData,
  input logic          holdErr
);

  assert_reset_cancels_R1: assert property (@(posedge clk) disable iff (!rstN)
    wrReset |=> !ramWe);

  assert_data_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (ramData == $past(dataIn, 2)));

  assert_mask_blocks_R3: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> $past(inEn, 2));

  assert_enable_gates_R4: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> $past(wrEn, 2));

  assert_no_reset_in_flight_R5: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> !$past(wrReset, 1));

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdErr) |-> !$past(wrReset));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (holdErr && !wrReset) |=> holdErr);

endmodule

bind field_wr_port field_wr_port_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrReset (wrReset),
  .wrEn    (wrEn),
  .inEn    (inEn),
  .dataIn  (dataIn),
  .ramWe   (ramWe),
  .ramData (ramData),
  .holdErr (holdErr)
);

// File: tb/field_wr_port_bench.sv
`timescale 1ns/1ps
module field_wr_port_bench;

  localparam int DEPTH = 16;
  localparam int DW    = 16;
  localparam int HOLD  = 8;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrReset = 1'b0;
  logic          wrEn = 1'b0;
  logic          inEn = 1'b0;
  logic [DW-1:0] dataIn = '0;
  logic          ramWe;
  logic [AW-1:0] ramAddr;
  logic [DW-1:0] ramData;
  logic          holdErr;

  always #2.5 clk = ~clk;

  field_wr_port #(.DEPTH(DEPTH), .DW(DW), .HOLD_CYCLES(HOLD)) u_field_wr_port (
    .clk(clk), .rstN(rstN), .wrReset(wrReset), .wrEn(wrEn), .inEn(inEn),
    .dataIn(dataIn), .ramWe(ramWe), .ramAddr(ramAddr), .ramData(ramData),
    .holdErr(holdErr)
  );

  typedef struct {
    int          edgeNo;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    string       req;
  } expItem_t;

  expItem_t q[$];
  int edgeCnt = 0;
  int vectors = 0;
  int misses  = 0;
  bit done    = 0;

  // bench model state: 0 hold, 1 armed, 2 start, 3 run
  int  mState = 0;
  int  mHold  = HOLD;
  int  mPtr   = 0;
  bit  mErr   = 0;
  bit  mFirst = 0;
  bit  mPrevMasked = 0;
  bit  mPrevIdle = 0;

  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  task automatic modelReset();
    mState = 0; mHold = HOLD; mPtr = 0; mErr = 0; mFirst = 1;
    mPrevMasked = 0; mPrevIdle = 0;
  endtask

  task automatic step(input bit rst, input bit we, input bit ie, input logic [DW-1:0] d);
    int n;
    expItem_t it;
    @(negedge clk);
    n = edgeCnt;
    wrReset = rst; wrEn = we; inEn = ie; dataIn = d;
    if (rst) begin
      while (q.size() > 0 && q[$].edgeNo == n + 1) void'(q.pop_back());
      modelReset();
    end else begin
      case (mState)
        0: begin
          if (we) mErr = 1;
          if (mHold <= 1) mState = 1; else mHold = mHold - 1;
        end
        1: if (we) mState = 2;
        2: begin
          if (!we) mErr = 1;
          mState = 3;
        end
        default: begin
          if (we) begin
            if (ie) begin
              it.edgeNo = n + 2;
              it.addr   = AW'(mPtr);
              it.data   = d;
              if (mFirst) it.req = "R6";
              else if (mPtr == 0) it.req = "R9";
              else if (mPrevMasked) it.req = "R3";
              else if (mPrevIdle) it.req = "R4";
              else it.req = "R2";
              q.push_back(it);
              mFirst = 0;
            end
            mPrevMasked = !ie;
            mPrevIdle = 0;
            mPtr = (mPtr + 1) % DEPTH;
          end else begin
            mPrevIdle = 1;
          end
        end
      endcase
    end
  endtask

  task automatic checkErr(input string req);
    @(posedge clk);
    #1;
    vectors++;
    if (holdErr !== mErr) begin
      misses++;
      $display("FAIL %s holdErr actual %0b expected %0b", req, holdErr, mErr);
    end
  endtask

  // monitor: compares the RAM port against the scoreboard queue
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (ramWe === 1'b1) begin
        vectors++;
        if (q.size() == 0 || q[0].edgeNo != edgeCnt) begin
          misses++;
          $display("FAIL R5 unexpected write actual addr %0d data %h expected no write at edge %0d",
                   ramAddr, ramData, edgeCnt);
        end else begin
          expItem_t e;
          e = q.pop_front();
          if (ramAddr !== e.addr || ramData !== e.data) begin
            misses++;
            $display("FAIL %s actual addr %0d data %h expected addr %0d data %h",
                     e.req, ramAddr, ramData, e.addr, e.data);
          end
        end
      end else if (q.size() > 0 && q[0].edgeNo == edgeCnt) begin
        expItem_t e;
        e = q.pop_front();
        vectors++;
        misses++;
        $display("FAIL %s missing write actual ramWe %b expected addr %0d data %h",
                 e.req, ramWe, e.addr, e.data);
      end
    end
  end

  initial begin
    #(200000 * 5);
    misses++;
    $display("FAIL watchdog actual hung expected completion");
    report();
  end

  initial begin
    // R10: system reset state
    repeat (3) @(negedge clk);
    #1;
    vectors++;
    if (ramWe !== 1'b0 || holdErr !== 1'b0) begin
      misses++;
      $display("FAIL R10 actual ramWe %b holdErr %b expected 0 0", ramWe, holdErr);
    end
    @(negedge clk);
    rstN = 1'b1;
    modelReset();

    // field reset, clean hold-off, unbroken run past the wrap (R1, R6, R9)
    step(1, 0, 0, '0);
    for (int i = 0; i < HOLD + 2; i++) step(0, 0, 1, 16'hdead);
    step(0, 1, 1, 16'h1111);
    step(0, 1, 1, 16'h2222);
    for (int i = 0; i < 20; i++) step(0, 1, 1, 16'h0100 + 16'(i));
    // toggling mask (R3)
    for (int i = 0; i < 8; i++) step(0, 1, (i % 2) == 0, 16'h0200 + 16'(i));
    // pointer enable gaps with mask high (R4)
    for (int i = 0; i < 8; i++) step(0, (i % 3) == 0, 1, 16'h0300 + 16'(i));
    checkErr("R7");

    // reset mid-stream cancels in-flight words (R1)
    step(0, 1, 1, 16'h0401);
    step(0, 1, 1, 16'h0402);
    step(1, 1, 1, 16'h0403);
    checkErr("R1");
    // raise inside hold-off is ignored and flagged (R7)
    step(0, 0, 1, 16'h0501);
    step(0, 1, 1, 16'h0502);
    checkErr("R7");
    for (int i = 0; i < HOLD; i++) step(0, 0, 1, 16'h0600);
    checkErr("R7");
    step(0, 1, 1, 16'h0701);
    step(0, 1, 1, 16'h0702);
    for (int i = 0; i < 5; i++) step(0, 1, 1, 16'h0800 + 16'(i));

    // new reset clears the flag; drop during start-up is flagged (R8)
    step(1, 0, 0, '0);
    checkErr("R1");
    for (int i = 0; i < HOLD; i++) step(0, 0, 0, '0);
    step(0, 1, 1, 16'h0901);
    step(0, 0, 1, 16'h0902);
    checkErr("R8");
    step(0, 0, 1, 16'h0903);
    for (int i = 0; i < 4; i++) step(0, 1, 1, 16'h0a00 + 16'(i));
    step(0, 0, 0, '0);
    repeat (4) step(0, 0, 0, '0);

    @(negedge clk);
    vectors++;
    if (q.size() != 0) begin
      misses++;
      $display("FAIL R5 pending writes actual %0d expected 0", q.size());
    end
    report();
  end

endmodule